// File: doc/BRIEF.md
# Link-Training Monitor with Receiver Stall Recovery

This block supervises link training on a serial-link controller after software or a sequencer kicks it with a start strobe. It samples the controller's link-up indication at the start of the run and again at the end of every poll, and declares success as soon as that indication is seen. Between checks it waits a programmable interval and then reads the lane receiver status word through a control-register request port.

The block also watches for one particular hang. A speed change toward the second signalling rate can stall when the training state machine is stuck in the receiver-lock recovery state (encoded 0x0D) while the receiver reports no valid data. In that case the block forces a receiver reset. It sets two override bits in the lane receiver override register, holds them for one interval, and then clears them. When the poll budget runs out without link-up, it reports failure. The training logic and the register-bus master that serves the requests sit outside the block.

Top module: `link_train_monitor`

## Requirements
- R1: After reset, link_ok, link_fail and req_valid are low. A one-cycle start pulse begins a run when the block is idle or has finished. A start pulse while a run is in progress has no effect on the outcome or its timing.
- R2: link_up is sampled once at the start of a run and once after each poll. If it is high, link_ok rises on the next cycle without any further request. link_ok then stays high with no requests until the next start.
- R3: A poll waits INTERVAL_CYC cycles and then issues a read (req_write=0) of address 0x100D. The receiver-valid flag is bit 0 of the returned word. Bits 1 and 2 (PLL state, loss of signal) do not affect the decision.
- R4: When a read completes with ltssm_state equal to 0x0D and rdata bit 0 equal to 0, the block writes 0x0028 to address 0x1005. This word sets override bits 3 and 5. The block then waits INTERVAL_CYC cycles, writes 0x0000 to 0x1005, and then checks link_up. If either condition is absent, no write is issued.
- R5: After MAX_POLLS polls without link-up, link_fail rises on the cycle after the final check and stays high until the next start.
- R6: link_ok and link_fail are never high together.
- R7: Only one request is outstanding at a time. req_valid, req_write, req_addr and req_wdata hold steady until req_done, and the cycle after req_done begins the next step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that begins a monitoring run |
| link_up | input | 1 | Link-up indication from the controller debug status |
| ltssm_state | input | 6 | Current training state code |
| req_valid | output | 1 | Control-register request pending |
| req_write | output | 1 | 1 = write, 0 = read |
| req_addr | output | 16 | Control-register address |
| req_wdata | output | 16 | Write data |
| req_done | input | 1 | Request completed (read data valid this cycle) |
| req_rdata | input | 16 | Read data returned with req_done |
| link_ok | output | 1 | Link came up |
| link_fail | output | 1 | Poll budget exhausted without link-up |

## Verification
Assertions check four properties on every cycle. The two outcome flags stay mutually exclusive and persist until a new start. A pending request holds its fields until it completes. Reads target only the status address and writes target only the override register.

Some behaviour shows only in the bench's scenarios, which sweep every training state code against both receiver-valid values and several bus latencies. These scenarios show that the recovery pulse pair is issued exactly when the stall condition holds. They also show that the override words alternate in the right order. They check the exact cycle at which failure is declared for a given interval, latency and stall count, and that link-up arriving mid-run ends polling.

// File: rtl/lm_pkg.sv
package lm_pkg;

    localparam int CR_AW = 16;
    localparam int CR_DW = 16;
    localparam int STATE_W = 6;

    localparam logic [STATE_W-1:0] RCVR_LOCK_CODE = 6'h0D;
    localparam logic [CR_AW-1:0]   RX_STATUS_ADDR = 16'h100D;
    localparam logic [CR_AW-1:0]   RX_OVERRIDE_ADDR = 16'h1005;
    localparam logic [CR_DW-1:0]   OVERRIDE_SET = 16'h0028;
    localparam logic [CR_DW-1:0]   OVERRIDE_CLR = 16'h0000;
    localparam int                 RX_VALID_POS = 0;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CHECK,
        ST_WAIT,
        ST_READ,
        ST_SET,
        ST_HOLD,
        ST_CLEAR,
        ST_OK,
        ST_FAIL
    } mon_state_t;

    typedef struct packed {
        logic             valid;
        logic             write;
        logic [CR_AW-1:0] addr;
        logic [CR_DW-1:0] wdata;
    } cr_req_t;

    function automatic logic rx_stalled(input logic [STATE_W-1:0] st,
                                        input logic rx_valid);
        return (st == RCVR_LOCK_CODE) && !rx_valid;
    endfunction

endpackage

// File: rtl/lm_interval_timer.sv
module lm_interval_timer #(
    parameter int CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic expired
);
    localparam int W = (CYCLES > 1) ? $clog2(CYCLES) : 1;

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= W'(CYCLES - 1);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/lm_poll_counter.sv
module lm_poll_counter #(
    parameter int MAX = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic incr,
    output logic exhausted
);
    localparam int W = $clog2(MAX + 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (incr) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign exhausted = (cnt == W'(MAX));

    assert_budget_R5: assert property (@(posedge clk) disable iff (rst)
        (cnt <= W'(MAX)));

endmodule

// File: rtl/lm_req_encode.sv
module lm_req_encode
    import lm_pkg::*;
(
    input  mon_state_t state,
    output cr_req_t    req
);
    always_comb begin
        req = '0;
        unique case (state)
            ST_READ: begin
                req.valid = 1'b1;
                req.addr  = RX_STATUS_ADDR;
            end
            ST_SET: begin
                req.valid = 1'b1;
                req.write = 1'b1;
                req.addr  = RX_OVERRIDE_ADDR;
                req.wdata = OVERRIDE_SET;
            end
            ST_CLEAR: begin
                req.valid = 1'b1;
                req.write = 1'b1;
                req.addr  = RX_OVERRIDE_ADDR;
                req.wdata = OVERRIDE_CLR;
            end
            default: req = '0;
        endcase
    end

endmodule

// File: rtl/link_train_monitor.sv
module link_train_monitor
    import lm_pkg::*;
#(
    parameter int INTERVAL_CYC = 500000,
    parameter int MAX_POLLS = 200
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                link_up,
    input  logic [STATE_W-1:0]  ltssm_state,
    output logic                req_valid,
    output logic                req_write,
    output logic [CR_AW-1:0]    req_addr,
    output logic [CR_DW-1:0]    req_wdata,
    input  logic                req_done,
    input  logic [CR_DW-1:0]    req_rdata,
    output logic                link_ok,
    output logic                link_fail
);
    mon_state_t state, state_n;
    cr_req_t    req;
    logic       tmr_load, tmr_expired;
    logic       poll_clear, poll_incr, poll_exhausted;
    logic       stall_now;
    logic       unused_rdata_hi;

    assign unused_rdata_hi = ^req_rdata[CR_DW-1:1];
    assign stall_now = rx_stalled(ltssm_state, req_rdata[RX_VALID_POS]);

    lm_interval_timer #(.CYCLES(INTERVAL_CYC)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (tmr_load),
        .expired (tmr_expired)
    );

    lm_poll_counter #(.MAX(MAX_POLLS)) u_polls (
        .clk       (clk),
        .rst       (rst),
        .clear     (poll_clear),
        .incr      (poll_incr),
        .exhausted (poll_exhausted)
    );

    lm_req_encode u_enc (
        .state (state),
        .req   (req)
    );

    always_comb begin
        state_n    = state;
        poll_clear = 1'b0;
        poll_incr  = 1'b0;
        unique case (state)
            ST_IDLE, ST_OK, ST_FAIL: begin
                if (start) begin
                    state_n    = ST_CHECK;
                    poll_clear = 1'b1;
                end
            end
            ST_CHECK: begin
                if (link_up) begin
                    state_n = ST_OK;
                end else if (poll_exhausted) begin
                    state_n = ST_FAIL;
                end else begin
                    state_n   = ST_WAIT;
                    poll_incr = 1'b1;
                end
            end
            ST_WAIT:  if (tmr_expired) state_n = ST_READ;
            ST_READ:  if (req_done) state_n = stall_now ? ST_SET : ST_CHECK;
            ST_SET:   if (req_done) state_n = ST_HOLD;
            ST_HOLD:  if (tmr_expired) state_n = ST_CLEAR;
            ST_CLEAR: if (req_done) state_n = ST_CHECK;
            default:  state_n = ST_IDLE;
        endcase
    end

    assign tmr_load = ((state_n == ST_WAIT) && (state != ST_WAIT)) ||
                      ((state_n == ST_HOLD) && (state != ST_HOLD));

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_n;
        end
    end

    assign req_valid = req.valid;
    assign req_write = req.write;
    assign req_addr  = req.addr;
    assign req_wdata = req.wdata;
    assign link_ok   = (state == ST_OK);
    assign link_fail = (state == ST_FAIL);

    assert_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
        !(link_ok && link_fail));

    assert_req_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_done) |=> (req_valid && $stable(req_addr) &&
                                      $stable(req_write) && $stable(req_wdata)));

    assert_write_target_R4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write) |-> (req_addr == RX_OVERRIDE_ADDR));

    assert_read_target_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write) |-> (req_addr == RX_STATUS_ADDR));

    assert_ok_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        link_ok |-> !req_valid);

    assert_ok_sticky_R2: assert property (@(posedge clk) disable iff (rst)
        (link_ok && !start) |=> link_ok);

    assert_ok_cause_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(link_ok) |-> $past(link_up));

    assert_fail_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        (link_fail && !start) |=> link_fail);

endmodule

// File: tb/link_train_monitor_tb.sv
`timescale 1ns/1ps
module link_train_monitor_tb;
    localparam int I = 4;
    localparam int P = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        link_up = 1'b0;
    logic [5:0]  ltssm_state = 6'h00;
    logic        req_valid, req_write;
    logic [15:0] req_addr, req_wdata;
    logic        req_done = 1'b0;
    logic [15:0] req_rdata = 16'h0;
    logic        link_ok, link_fail;

    int checks = 0;
    int errors = 0;
    int reads = 0;
    int writes = 0;
    int bad = 0;
    int lat_sel = 0;
    int lat_cnt = 0;
    logic [15:0] rx_word = 16'h0;
    logic [15:0] exp_w = 16'h0028;

    always #2.5 clk = ~clk;

    link_train_monitor #(.INTERVAL_CYC(I), .MAX_POLLS(P)) u_dut (
        .clk(clk), .rst(rst), .start(start), .link_up(link_up),
        .ltssm_state(ltssm_state), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_done(req_done),
        .req_rdata(req_rdata), .link_ok(link_ok), .link_fail(link_fail)
    );

    // register-bus responder with programmable latency
    always @(posedge clk) begin
        if (rst) begin
            req_done <= 1'b0;
            lat_cnt = 0;
        end else begin
            req_done <= 1'b0;
            if (req_valid && !req_done) begin
                if (lat_cnt >= lat_sel) begin
                    req_done <= 1'b1;
                    req_rdata <= rx_word;
                    lat_cnt = 0;
                    if (req_write) begin
                        writes++;
                        if (req_addr != 16'h1005) bad++;
                        if (req_wdata != exp_w) bad++;
                        exp_w = (exp_w == 16'h0028) ? 16'h0000 : 16'h0028;
                    end else begin
                        reads++;
                        if (req_addr != 16'h100D) bad++;
                    end
                end else begin
                    lat_cnt++;
                end
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // one run; returns negedge count until an outcome is visible
    task automatic do_run(input logic [5:0] st, input logic [15:0] rx,
                          input int lat, input int link_after,
                          input bit pulse_mid, output int n);
        ltssm_state = st;
        rx_word = rx;
        lat_sel = lat;
        link_up = (link_after == 0);
        reads = 0; writes = 0; bad = 0; exp_w = 16'h0028;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        n = 1;
        while (!(link_ok || link_fail) && n < 20000) begin
            if (link_after > 0 && reads >= link_after) link_up = 1'b1;
            start = (pulse_mid && n == 7);
            @(negedge clk);
            n++;
        end
        start = 1'b0;
    endtask

    function automatic int fail_cycles(input int lat, input int stalls);
        return P * (I + lat + 3) + 1 + stalls * (I + 2 * lat + 4) + 1;
    endfunction

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        int okc;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset link_ok", link_ok, 0);
        chk("R1 reset link_fail", link_fail, 0);
        chk("R1 reset req_valid", req_valid, 0);

        // R2: link already up at start
        do_run(6'h11, 16'h0001, 0, 0, 0, n);
        chk("R2 immediate ok", link_ok, 1);
        chk("R2 immediate timing", n, 2);
        chk("R2 immediate no reads", reads, 0);
        repeat (5) @(negedge clk);
        chk("R2 ok sticky", link_ok, 1);
        chk("R2 ok quiet", reads + writes, 0);
        chk("R6 ok excludes fail", link_fail, 0);

        // R2: link appears after third poll
        do_run(6'h11, 16'h0001, 1, 3, 0, n);
        chk("R2 mid-run ok", link_ok, 1);
        chk("R2 mid-run reads", reads, 3);
        chk("R6 mid-run fail low", link_fail, 0);

        // R5/R3: budget exhausted, no stall
        do_run(6'h11, 16'h0001, 2, -1, 0, n);
        chk("R5 fail flag", link_fail, 1);
        chk("R5 fail timing", n, fail_cycles(2, 0));
        chk("R3 read count", reads, P);
        chk("R3 read address", bad, 0);
        repeat (5) @(negedge clk);
        chk("R5 fail sticky", link_fail, 1);

        // R1: start during a run ignored
        do_run(6'h11, 16'h0001, 2, -1, 1, n);
        chk("R1 busy start timing", n, fail_cycles(2, 0));
        chk("R1 busy start reads", reads, P);

        // R4: stall with status bits 1,2 set, valid clear
        do_run(6'h0D, 16'h0006, 1, -1, 0, n);
        chk("R4 stall writes", writes, 2 * P);
        chk("R4 stall word order", bad, 0);
        chk("R4 stall timing", n, fail_cycles(1, P));

        // R4 + R2: recovery pulse then link comes up
        do_run(6'h0D, 16'h0000, 0, 2, 0, n);
        chk("R4 recovery then ok", link_ok, 1);
        chk("R4 recovery writes", writes, 4);

        // R3/R4/R5/R7: sweep all state codes x receiver valid
        for (int s = 0; s < 64; s++) begin
            for (int v = 0; v < 2; v++) begin
                int exp_stall;
                int lat;
                lat = s % 3;
                exp_stall = (s == 13 && v == 0) ? P : 0;
                do_run(6'(s), (v == 1) ? 16'h0007 : 16'hFFFE, lat, -1, 0, n);
                chk($sformatf("R5 sweep fail s=%0d v=%0d", s, v), link_fail, 1);
                chk($sformatf("R6 sweep ok low s=%0d v=%0d", s, v), link_ok, 0);
                chk($sformatf("R3 sweep reads s=%0d v=%0d", s, v), reads, P);
                chk($sformatf("R4 sweep writes s=%0d v=%0d", s, v), writes, 2 * exp_stall);
                chk($sformatf("R7 sweep timing s=%0d v=%0d", s, v), n,
                    fail_cycles(lat, exp_stall));
                chk($sformatf("R4 sweep words s=%0d v=%0d", s, v), bad, 0);
            end
        end

        okc = 0;
        $display("CHECKS %0d ERRORS %0d", checks, errors + okc);
        $finish;
    end

endmodule